// File: doc/BRIEF.md
# Level-Based Interrupt Priority Controller

This block gathers interrupt requests from a set of on-chip peripheral sources and presents at most one request to the CPU. Each source has a pending flag, which a pulse on its request line sets, and an enable input. It also has a software-programmed three-bit priority level held in its own level register. Of all sources that are both pending and enabled, the controller picks the one with the numerically lowest level. Level 0 is the most urgent and level 7 switches a source off. When two sources share a level, the lower index wins.

The winning level is then compared with the CPU's current interrupt level mask. A request goes out only when the winner's level is strictly below the mask and the CPU's global interrupt enable is set. The outgoing request, its level and its source number are registered. They stay frozen until the CPU acknowledges. The acknowledge clears the pending flag of the acknowledged source, and arbitration then resumes among the sources still pending.

Top module: `irq_level_ctrl`

## Requirements
- R1: A source competes only while both its pending flag and its enable input `src_en[i]` are 1; a pending but disabled source keeps its flag and can win once it is enabled.
- R2: A cycle with `lvl_wr`=1 writes `lvl_wr_data` into the level register of source `lvl_wr_idx` at that clock edge; the new level governs arbitration from the next cycle on.
- R3: Among competing sources the one with the numerically smallest level wins; a source whose level is 7 never wins.
- R4: When competing sources share the smallest level, the one with the lowest index wins.
- R5: A request is raised only if the winner's level is strictly less than `cpu_ilm` and `cpu_ie` is 1.
- R6: `irq_req`, `irq_level` and `irq_src` are registered. While `irq_req` is 0 they follow the arbitration result one cycle later and read 7 and 0 when there is no request. Once `irq_req` is 1 all three hold unchanged until `irq_ack`, whatever the other inputs do.
- R7: `irq_ack` while `irq_req` is 1 clears the pending flag of source `irq_src` and drops `irq_req` at that edge; a fresh result appears one cycle later. `irq_ack` while `irq_req` is 0 has no effect.
- R8: `src_req[i]`=1 sets the pending flag of source i at the clock edge; a set in the same cycle as an acknowledge of that source leaves the flag set.
- R9: Reset sets every level register to 7, clears every pending flag and drives `irq_req`=0, `irq_level`=7, `irq_src`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| src_req | input | N_SRC | Per-source request pulses, each setting the pending flag |
| src_en | input | N_SRC | Per-source enable bits |
| lvl_wr | input | 1 | Level register write strobe |
| lvl_wr_idx | input | IDX_W | Source whose level register is written |
| lvl_wr_data | input | 3 | Level value to write |
| cpu_ilm | input | 3 | CPU current interrupt level mask |
| cpu_ie | input | 1 | CPU global interrupt enable |
| irq_ack | input | 1 | CPU acknowledge of the presented request |
| irq_req | output | 1 | Request to the CPU |
| irq_level | output | 3 | Level of the presented request (7 when idle) |
| irq_src | output | IDX_W | Source number of the presented request (0 when idle) |

## Verification
The hardest situation to reach is a set of several pending flags with mixed levels, ties and disabled sources, seen under every mask value. Flags only leave through acknowledges, so a stale flag would corrupt the next case. The stimulus loads each level pattern while `cpu_ie` is low and pulses every request line at once. It then enables the CPU side and acknowledges winner after winner, checking each against an arithmetic model. Afterwards it forces every level to 0 and drains the leftovers, which restores an empty state before the next pattern. Directed cases cover a request that must hold while the mask closes, an acknowledge that arrives while idle, and a re-request in the same cycle as its own acknowledge.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int unsigned IRQ_LVL_W = 3;
  typedef logic [IRQ_LVL_W-1:0] irq_lvl_t;
  // Level value that switches a source off.
  localparam irq_lvl_t IRQ_LVL_OFF = '1;
endpackage

// File: rtl/irq_level_regs.sv
`timescale 1ns/1ps
module irq_level_regs
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  irq_lvl_t             wr_lvl,
  output irq_lvl_t [N_SRC-1:0] lvl_o
);
  irq_lvl_t [N_SRC-1:0] lvl_q;
  logic     [N_SRC-1:0] lvl_ce;

  for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
    always_comb begin
      lvl_ce[i] = wr_en && (wr_idx == IDX_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[i] <= IRQ_LVL_OFF;
      end else if (lvl_ce[i]) begin
        lvl_q[i] <= wr_lvl;
      end
    end

    // R2: a write lands in the addressed register at the edge
    p_lvl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i)) |=> (lvl_q[i] == $past(wr_lvl)));
    // R2: other registers keep their value
    p_lvl_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(lvl_q[i]));
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [N_SRC-1:0] live_o
);
  logic [N_SRC-1:0] flag_q;
  logic [N_SRC-1:0] flag_nxt;
  logic [N_SRC-1:0] flag_ce;

  // Set dominates clear so a request arriving with its own acknowledge survives.
  always_comb begin
    flag_nxt = (flag_q & ~clr_i) | set_i;
    flag_ce  = set_i | clr_i;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else if (flag_ce[i]) begin
        flag_q[i] <= flag_nxt[i];
      end
    end

    p_set_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]);
    p_clr_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
    p_flag_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[i] && !clr_i[i]) |=> $stable(flag_q[i]));
  end

  assign live_o = flag_q & en_i;
endmodule

// File: rtl/irq_prio_sel.sv
`timescale 1ns/1ps
module irq_prio_sel
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic     [N_SRC-1:0] live_i,
  input  irq_lvl_t [N_SRC-1:0] lvl_i,
  output logic                 win_vld,
  output irq_lvl_t             win_lvl,
  output logic     [IDX_W-1:0] win_idx
);
  // Linear chain from index 0 upward; strict compare keeps the lower index on ties.
  logic     [N_SRC:0] vld_c;
  irq_lvl_t           lvl_c [N_SRC+1];
  logic [IDX_W-1:0]   idx_c [N_SRC+1];
  logic [N_SRC-1:0]   cand;
  logic [N_SRC-1:0]   take;

  assign vld_c[0] = 1'b0;
  assign lvl_c[0] = IRQ_LVL_OFF;
  assign idx_c[0] = '0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_stage
    always_comb begin
      cand[i]      = live_i[i] && (lvl_i[i] != IRQ_LVL_OFF);
      take[i]      = cand[i] && (!vld_c[i] || (lvl_i[i] < lvl_c[i]));
      vld_c[i+1]   = vld_c[i] | cand[i];
      lvl_c[i+1]   = take[i] ? lvl_i[i] : lvl_c[i];
      idx_c[i+1]   = take[i] ? IDX_W'(i) : idx_c[i];
    end
  end

  assign win_vld = vld_c[N_SRC];
  assign win_lvl = lvl_c[N_SRC];
  assign win_idx = idx_c[N_SRC];
endmodule

// File: rtl/irq_out_stage.sv
`timescale 1ns/1ps
module irq_out_stage
  import irq_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_vld,
  input  irq_lvl_t         win_lvl,
  input  logic [IDX_W-1:0] win_idx,
  input  irq_lvl_t         cpu_ilm,
  input  logic             cpu_ie,
  input  logic             ack_i,
  output logic             req_o,
  output irq_lvl_t         lvl_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             take_o
);
  logic             req_q, req_nxt;
  irq_lvl_t         lvl_q, lvl_nxt;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             pass;
  logic             out_ce;

  always_comb begin
    pass    = win_vld && cpu_ie && (win_lvl < cpu_ilm);
    take_o  = req_q && ack_i;
    out_ce  = !req_q || ack_i;
    req_nxt = 1'b0;
    lvl_nxt = IRQ_LVL_OFF;
    idx_nxt = '0;
    if (!req_q && pass) begin
      req_nxt = 1'b1;
      lvl_nxt = win_lvl;
      idx_nxt = win_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= IRQ_LVL_OFF;
      idx_q <= '0;
    end else if (out_ce) begin
      req_q <= req_nxt;
      lvl_q <= lvl_nxt;
      idx_q <= idx_nxt;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_i) |=> (req_q && $stable(lvl_q) && $stable(idx_q)));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |-> (lvl_q == IRQ_LVL_OFF && idx_q == '0));
  p_mask_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> ($past(cpu_ie) && (lvl_q < $past(cpu_ilm))));
  p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && ack_i) |=> !req_q);

  assign req_o = req_q;
  assign lvl_o = lvl_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/irq_level_ctrl.sv
`timescale 1ns/1ps
module irq_level_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     src_req,
  input  logic [N_SRC-1:0]     src_en,
  input  logic                 lvl_wr,
  input  logic [IDX_W-1:0]     lvl_wr_idx,
  input  logic [IRQ_LVL_W-1:0] lvl_wr_data,
  input  logic [IRQ_LVL_W-1:0] cpu_ilm,
  input  logic                 cpu_ie,
  input  logic                 irq_ack,
  output logic                 irq_req,
  output logic [IRQ_LVL_W-1:0] irq_level,
  output logic [IDX_W-1:0]     irq_src
);
  irq_lvl_t [N_SRC-1:0] lvl;
  logic     [N_SRC-1:0] live;
  logic     [N_SRC-1:0] clr;
  logic                 win_vld;
  irq_lvl_t             win_lvl;
  logic     [IDX_W-1:0] win_idx;
  logic                 take;

  irq_level_regs #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .wr_en(lvl_wr), .wr_idx(lvl_wr_idx),
    .wr_lvl(lvl_wr_data), .lvl_o(lvl)
  );

  irq_flag_bank #(.N_SRC(N_SRC)) u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(src_req), .clr_i(clr),
    .en_i(src_en), .live_o(live)
  );

  irq_prio_sel #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_sel (
    .live_i(live), .lvl_i(lvl), .win_vld(win_vld), .win_lvl(win_lvl),
    .win_idx(win_idx)
  );

  irq_out_stage #(.IDX_W(IDX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_lvl(win_lvl),
    .win_idx(win_idx), .cpu_ilm(cpu_ilm), .cpu_ie(cpu_ie), .ack_i(irq_ack),
    .req_o(irq_req), .lvl_o(irq_level), .idx_o(irq_src), .take_o(take)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_clr
    assign clr[i] = take && (irq_src == IDX_W'(i));
  end

  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
  p_clr_only_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |-> (clr == '0));
endmodule

// File: tb/irq_level_ctrl_bench.sv
`timescale 1ns/1ps
module irq_level_ctrl_bench;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] src_req, src_en;
  logic       lvl_wr;
  logic [2:0] lvl_wr_idx, lvl_wr_data, cpu_ilm;
  logic       cpu_ie, irq_ack;
  logic       irq_req;
  logic [2:0] irq_level, irq_src;

  int n_cmp = 0;
  int n_bad = 0;
  int m_lvl [N];
  bit m_flag [N];
  bit m_en [N];
  int m_ilm;
  bit m_ie;

  always #2.5 clk = ~clk;

  irq_level_ctrl #(.N_SRC(N)) u_irq_level_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .lvl_wr(lvl_wr), .lvl_wr_idx(lvl_wr_idx), .lvl_wr_data(lvl_wr_data),
    .cpu_ilm(cpu_ilm), .cpu_ie(cpu_ie), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_level(irq_level), .irq_src(irq_src)
  );

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not complete (got hang, expected finish)");
    finish_run();
  end

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Arithmetic model of arbitration plus the mask test.
  task automatic model(output bit pass, output int lvl, output int src);
    bit v = 0;
    lvl = 7;
    src = 0;
    for (int i = 0; i < N; i++)
      if (m_flag[i] && m_en[i] && m_lvl[i] != 7 && (!v || m_lvl[i] < lvl)) begin
        v = 1; lvl = m_lvl[i]; src = i;
      end
    pass = v && m_ie && (lvl < m_ilm);
    if (!pass) begin lvl = 7; src = 0; end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(int idx, int l);
    lvl_wr = 1; lvl_wr_idx = idx[2:0]; lvl_wr_data = l[2:0];
    cyc(1);
    lvl_wr = 0;
    m_lvl[idx] = l;
  endtask

  task automatic set_en(logic [7:0] e);
    src_en = e;
    for (int i = 0; i < N; i++) m_en[i] = e[i];
  endtask

  task automatic pulse(logic [7:0] m);
    src_req = m;
    cyc(1);
    src_req = '0;
    for (int i = 0; i < N; i++) if (m[i]) m_flag[i] = 1;
  endtask

  task automatic cpu(int ilm, bit ie);
    cpu_ilm = ilm[2:0]; cpu_ie = ie; m_ilm = ilm; m_ie = ie;
  endtask

  task automatic check_out(string tag);
    bit p; int l, s;
    model(p, l, s);
    chk({tag, " irq_req"}, int'(irq_req), int'(p));
    chk({tag, " irq_level"}, int'(irq_level), l);
    chk({tag, " irq_src"}, int'(irq_src), s);
  endtask

  task automatic ack_once();
    bit p; int l, s;
    model(p, l, s);
    irq_ack = 1;
    cyc(1);
    irq_ack = 0;
    if (p) m_flag[s] = 0;
    cyc(1);
  endtask

  task automatic drain(string tag);
    for (int k = 0; k <= N; k++) begin
      bit p; int l, s;
      model(p, l, s);
      check_out(tag);
      if (!p) break;
      ack_once();
    end
  endtask

  task automatic clean();
    cpu(0, 0);
    set_en(8'hFF);
    for (int i = 0; i < N; i++) wr(i, 0);
    cpu(7, 1);
    cyc(2);
    drain("R4 cleanup");
    for (int i = 0; i < N; i++) wr(i, 7);
  endtask

  initial begin
    rst_n = 0; src_req = '0; src_en = '0; lvl_wr = 0; lvl_wr_idx = '0;
    lvl_wr_data = '0; cpu_ilm = '0; cpu_ie = 0; irq_ack = 0;
    for (int i = 0; i < N; i++) begin m_lvl[i] = 7; m_flag[i] = 0; m_en[i] = 0; end
    m_ilm = 0; m_ie = 0;
    cyc(3);
    // R9: idle outputs during and after reset
    check_out("R9 reset");
    rst_n = 1;
    cyc(1);
    check_out("R9 after release");

    // R9: all levels are 7 after reset, so pending sources never request
    set_en(8'hFF);
    cpu(7, 1);
    pulse(8'hFF);
    cyc(2);
    check_out("R9 levels off");
    // R2/R4: all levels 0 -> index order
    for (int i = 0; i < N; i++) wr(i, 0);
    cyc(1);
    drain("R4 equal levels");

    // R1: pending but disabled source waits
    wr(3, 2);
    set_en(8'hF7);
    pulse(8'h08);
    cyc(2);
    check_out("R1 disabled");
    set_en(8'hFF);
    cyc(2);
    check_out("R1 enabled");
    chk("R1 winner", int'(irq_src), 3);
    ack_once();
    check_out("R7 after ack");

    // R6: held request ignores mask and a more urgent source
    wr(2, 3);
    wr(0, 0);
    pulse(8'h04);
    cyc(2);
    chk("R6 req up", int'(irq_req), 1);
    chk("R6 src", int'(irq_src), 2);
    pulse(8'h01);
    cpu(0, 0);
    cyc(3);
    chk("R6 held req", int'(irq_req), 1);
    chk("R6 held level", int'(irq_level), 3);
    chk("R6 held src", int'(irq_src), 2);
    cpu(7, 1);
    m_flag[2] = 0;
    irq_ack = 1; cyc(1); irq_ack = 0;
    chk("R7 drop", int'(irq_req), 0);
    cyc(1);
    drain("R3 after hold");

    // R7: acknowledge while idle leaves the flag alone
    wr(5, 1);
    cpu(7, 0);
    pulse(8'h20);
    cyc(2);
    check_out("R5 ie off");
    irq_ack = 1; cyc(1); irq_ack = 0;
    cpu(7, 1);
    cyc(2);
    chk("R7 idle ack ignored", int'(irq_src), 5);
    chk("R7 idle ack ignored req", int'(irq_req), 1);
    // R8: re-request in the acknowledge cycle keeps the flag
    irq_ack = 1; src_req = 8'h20;
    cyc(1);
    irq_ack = 0; src_req = '0;
    cyc(1);
    chk("R8 set wins req", int'(irq_req), 1);
    chk("R8 set wins src", int'(irq_src), 5);
    drain("R8 drain");
    clean();

    // R2/R3/R4/R5/R1 sweep: every mask, several level patterns and enable sets
    for (int ilm = 0; ilm < 8; ilm++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 8; b += 2) begin
          cpu(ilm, 0);
          for (int i = 0; i < N; i++) wr(i, (((2 * a + (a > 0 ? 1 : 0)) * i) + b + ilm) % 8);
          set_en((a % 2 == 1) ? ~(8'h01 << ((b + ilm) % 8)) : 8'hFF);
          pulse(8'hFF);
          cpu(ilm, 1);
          cyc(2);
          drain("R3 R5 sweep");
          clean();
        end

    finish_run();
  end
endmodule